// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table out of memory. A requester hands over one address and an access kind through a ready/valid handshake. The walker reads the top-level entry to find the second-level table, then reads the second-level entry to get the frame number. It checks the valid and protection bits, marks the entry as referenced (and as modified on a write), and writes the entry back only if one of those bits actually changed. It then returns a one-cycle response carrying a status and, on success, the physical address.

The walker has a single-outstanding memory port: a request is held until the memory acknowledges it, and read data arrive with the acknowledge. A register holds the frame number of the top-level table. It is loaded through a dedicated strobe. Handling faults, filling tables and caching translations are left to other blocks.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0.
- R2: A table entry is 32 bits: frame number in bits 31:12, protection in bits 4:3, modify in bit 2, reference in bit 1, valid in bit 0; bits 11:5 are ignored. The top-level entry is read at `{root,12'h000} + 4*va[31:20]`. The second-level entry is read at `{top_frame,12'h000} + 4*va[19:12]`. Only the valid bit of the top-level entry is examined.
- R3: On success `rsp_status` is 00 and `rsp_paddr` is the second-level frame number joined with `va[11:0]`.
- R4: If the top-level entry has valid clear, the response is a page fault (status 01) with `rsp_paddr` 0, and no second read is made.
- R5: If the second-level entry has valid clear, the response is a page fault (status 01) with `rsp_paddr` 0.
- R6: Access kinds are 00 read, 01 write, 10 execute. Protection 00 allows nothing, 01 allows read, 10 allows read and write, and 11 allows read and execute. Kind 11 is never allowed. A valid entry that forbids the access gives a protection fault (status 10) with `rsp_paddr` 0.
- R7: On a successful access the reference bit is set, and on a write the modify bit is set too. The updated entry is written to the same address only if it differs from what was read. This write completes before the response. A fault writes nothing.
- R8: Only one request is in flight: `req_ready` is low from acceptance until the response, and `rsp_valid` is a one-cycle pulse after each accepted request.
- R9: While `mem_req` is high and not yet acknowledged, `mem_addr`, `mem_we` and `mem_wdata` stay constant, and every write carries an entry with valid and reference set.
- R10: Pulsing `root_load` stores `root_frame` as the top-level table frame. Requests accepted after the load use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_load | input | 1 | Load strobe for the top-level table frame |
| root_frame | input | 20 | Top-level table frame number |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 00 ok, 01 page fault, 10 protection fault |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
A wrong walk state or a wrong latched address shows up on the memory port within one access. It appears as an address that the table model cannot resolve, or as an extra or missing second read. It then reaches the response as a wrong frame or a wrong status in the same transaction. A wrong update of the reference and modify bits shows up as an unexpected or missing write, and as a changed entry in the table model before `rsp_valid` rises. Write-back is counted per transaction, so an update that should not change anything is caught as well.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        root_load,
  input  logic [19:0] root_frame,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic [1:0]  req_kind,
  output logic        rsp_valid,
  output logic [1:0]  rsp_status,
  output logic [31:0] rsp_paddr,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam logic [1:0] ST_OK = 2'b00, ST_PF = 2'b01, ST_PROT = 2'b10;
  localparam logic [1:0] K_RD = 2'b00, K_WR = 2'b01, K_EX = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_TOP, S_LEAF, S_WB, S_RSP} state_t;

  state_t      st;
  logic [19:0] root_q;
  logic [31:0] va_q;
  logic [1:0]  kind_q;
  logic [31:0] addr_q;
  logic [31:0] wdata_q;

  wire [1:0]  prot = mem_rdata[4:3];
  wire        ent_v = mem_rdata[0];
  wire        allow = (kind_q == K_RD) ? (prot != 2'b00) :
                      (kind_q == K_WR) ? (prot == 2'b10) :
                      (kind_q == K_EX) ? (prot == 2'b11) : 1'b0;
  wire [31:0] upd = mem_rdata | 32'h2 | ((kind_q == K_WR) ? 32'h4 : 32'h0);

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RSP);
  assign mem_req   = (st == S_TOP) || (st == S_LEAF) || (st == S_WB);
  assign mem_we    = (st == S_WB);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      root_q     <= '0;
      va_q       <= '0;
      kind_q     <= K_RD;
      addr_q     <= '0;
      wdata_q    <= '0;
      rsp_status <= ST_OK;
      rsp_paddr  <= '0;
    end else begin
      if (root_load) root_q <= root_frame;
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          kind_q <= req_kind;
          addr_q <= {root_q, 12'h000} + {18'd0, req_vaddr[31:20], 2'b00};
          st     <= S_TOP;
        end
        S_TOP: if (mem_ack) begin
          if (!ent_v) begin
            rsp_status <= ST_PF;
            rsp_paddr  <= '0;
            st         <= S_RSP;
          end else begin
            addr_q <= {mem_rdata[31:12], 2'b00, va_q[19:12], 2'b00};
            st     <= S_LEAF;
          end
        end
        S_LEAF: if (mem_ack) begin
          if (!ent_v || !allow) begin
            rsp_status <= ent_v ? ST_PROT : ST_PF;
            rsp_paddr  <= '0;
            st         <= S_RSP;
          end else begin
            rsp_status <= ST_OK;
            rsp_paddr  <= {mem_rdata[31:12], va_q[11:0]};
            wdata_q    <= upd;
            st         <= (upd != mem_rdata) ? S_WB : S_RSP;
          end
        end
        S_WB: if (mem_ack) st <= S_RSP;
        S_RSP: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_vaddr,
  input logic        rsp_valid,
  input logic [1:0]  rsp_status,
  input logic [31:0] rsp_paddr,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack
);
  logic        busy_q;
  logic [31:0] va_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      va_seen <= '0;
    end else if (req_valid && req_ready) begin
      busy_q  <= 1'b1;
      va_seen <= req_vaddr;
    end else if (rsp_valid) begin
      busy_q <= 1'b0;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> req_ready && !rsp_valid && !mem_req);
  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid);
  // R8
  rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> busy_q);
  // R8
  no_ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> !req_ready);
  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R9
  wb_bits_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req && mem_we |-> mem_wdata[1] && mem_wdata[0]);
  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status == 2'b00 |-> rsp_paddr[11:0] == va_seen[11:0]);
  // R4
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status != 2'b00 |-> rsp_paddr == 32'h0);
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
  .rsp_paddr(rsp_paddr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic root_load = 1'b0;
  logic [19:0] root_frame = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0] req_kind = '0;
  logic rsp_valid;
  logic [1:0] rsp_status;
  logic [31:0] rsp_paddr;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .root_load(root_load), .root_frame(root_frame),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_paddr(rsp_paddr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_fail = 0;
  int n_rd = 0, n_wr = 0;
  int wait_n = 0, lat = 0;
  bit done = 0;
  logic [31:0] tbl [logic [31:0]];
  logic [1:0]  q_st [$];
  logic [31:0] q_pa [$];
  string       q_tag [$];

  function automatic logic [31:0] pte(logic [19:0] fr, logic [1:0] pr, logic m, logic r, logic v);
    return {fr, 7'd0, pr, m, r, v};
  endfunction

  function automatic logic [31:0] rd_tbl(logic [31:0] a);
    if (tbl.exists(a)) return tbl[a];
    return 32'h0;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // table memory model with varying latency
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wait_n = 0;
    end else if (mem_req && !mem_ack) begin
      if (wait_n >= lat) begin
        mem_ack <= 1'b1;
        wait_n = 0;
        lat = (lat + 1) % 3;
        if (mem_we) begin
          tbl[mem_addr] = mem_wdata;
          n_wr++;
        end else begin
          mem_rdata <= rd_tbl(mem_addr);
          n_rd++;
        end
      end else wait_n++;
    end else mem_ack <= 1'b0;
  end

  // response monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_st.size() == 0) chk(0, "R8 unexpected response", {30'd0, rsp_status}, 32'h0);
      else begin
        string t;
        logic [1:0] es;
        logic [31:0] ep;
        t = q_tag.pop_front();
        es = q_st.pop_front();
        ep = q_pa.pop_front();
        chk(rsp_status == es, {t, " status"}, {30'd0, rsp_status}, {30'd0, es});
        chk(rsp_paddr == ep, {t, " paddr"}, rsp_paddr, ep);
      end
    end
  end

  task automatic walk(logic [31:0] va, logic [1:0] kind, logic [1:0] es, logic [31:0] ep,
                      int reads, int writes, string tag);
    int r0, w0;
    r0 = n_rd;
    w0 = n_wr;
    q_st.push_back(es);
    q_pa.push_back(ep);
    q_tag.push_back(tag);
    @(negedge clk);
    req_vaddr = va;
    req_kind = kind;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, {tag, " R8 busy"}, {31'd0, req_ready}, 32'h0);
    while (q_st.size() != 0) @(negedge clk);
    chk(n_rd - r0 == reads, {tag, " reads"}, n_rd - r0, reads);
    chk(n_wr - w0 == writes, {tag, " writes"}, n_wr - w0, writes);
  endtask

  task automatic load_root(logic [19:0] fr);
    @(negedge clk);
    root_frame = fr;
    root_load = 1'b1;
    @(negedge clk);
    root_load = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        chk(0, "watchdog", cyc, 100000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    tbl[32'h0001_0004] = pte(20'h00200, 2'b00, 0, 0, 1);
    tbl[32'h0020_0014] = pte(20'h01010, 2'b10, 0, 0, 1);
    tbl[32'h0020_001C] = pte(20'h02222, 2'b01, 0, 0, 1);
    tbl[32'h0020_0020] = pte(20'h03333, 2'b11, 0, 0, 1);
    tbl[32'h0020_0024] = pte(20'h04444, 2'b00, 0, 0, 1);
    tbl[32'h0002_0004] = pte(20'h00300, 2'b00, 0, 0, 1);
    tbl[32'h0030_0014] = pte(20'hABCDE, 2'b10, 0, 1, 1);
    tbl[32'h0002_3FFC] = pte(20'h00400, 2'b00, 0, 0, 1);
    tbl[32'h0040_03FC] = pte(20'hFFFFF, 2'b10, 0, 0, 1);

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready", {31'd0, req_ready}, 32'h1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", {31'd0, rsp_valid}, 32'h0);
    chk(mem_req == 1'b0, "R1 mem_req", {31'd0, mem_req}, 32'h0);
    rst_n = 1'b1;
    load_root(20'h00010);

    // R2 R3 R7: first read sets the reference bit
    walk(32'h0010_5678, 2'b00, 2'b00, 32'h0101_0678, 2, 1, "R3 read");
    chk(tbl[32'h0020_0014] == pte(20'h01010, 2'b10, 0, 1, 1), "R7 ref set",
        tbl[32'h0020_0014], pte(20'h01010, 2'b10, 0, 1, 1));
    walk(32'h0010_5000, 2'b00, 2'b00, 32'h0101_0000, 2, 0, "R7 read no wb");
    walk(32'h0010_5ABC, 2'b01, 2'b00, 32'h0101_0ABC, 2, 1, "R7 write");
    chk(tbl[32'h0020_0014] == pte(20'h01010, 2'b10, 1, 1, 1), "R7 mod set",
        tbl[32'h0020_0014], pte(20'h01010, 2'b10, 1, 1, 1));
    walk(32'h0010_5ABC, 2'b01, 2'b00, 32'h0101_0ABC, 2, 0, "R7 write no wb");
    // R4 top-level invalid
    walk(32'h0020_0123, 2'b00, 2'b01, 32'h0, 1, 0, "R4 top invalid");
    // R5 leaf invalid
    walk(32'h0010_6123, 2'b00, 2'b01, 32'h0, 2, 0, "R5 leaf invalid");
    // R6 protection
    walk(32'h0010_7010, 2'b01, 2'b10, 32'h0, 2, 0, "R6 write read-only");
    chk(tbl[32'h0020_001C] == pte(20'h02222, 2'b01, 0, 0, 1), "R7 fault untouched",
        tbl[32'h0020_001C], pte(20'h02222, 2'b01, 0, 0, 1));
    walk(32'h0010_7010, 2'b00, 2'b00, 32'h0222_2010, 2, 1, "R6 read read-only");
    walk(32'h0010_8444, 2'b10, 2'b00, 32'h0333_3444, 2, 1, "R6 exec read-exec");
    walk(32'h0010_5444, 2'b10, 2'b10, 32'h0, 2, 0, "R6 exec read-write");
    walk(32'h0010_9000, 2'b00, 2'b10, 32'h0, 2, 0, "R6 no access");
    walk(32'h0010_5000, 2'b11, 2'b10, 32'h0, 2, 0, "R6 reserved kind");
    // R10 new root
    load_root(20'h00020);
    walk(32'h0010_5FFF, 2'b00, 2'b00, 32'hABCD_EFFF, 2, 0, "R10 new root");
    // R2 top index and leaf index at maximum
    walk(32'hFFFF_F123, 2'b01, 2'b00, 32'hFFFF_F123, 2, 1, "R2 max index");
    chk(tbl[32'h0040_03FC] == pte(20'hFFFFF, 2'b10, 1, 1, 1), "R7 max entry",
        tbl[32'h0040_03FC], pte(20'hFFFFF, 2'b10, 1, 1, 1));

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule